// File: doc/BRIEF.md
# Card Status-Change Interrupt Controller

This block collects socket events into one interrupt status byte and drives one host interrupt line from it. Five live socket status lines are brought into the clock domain through a synchronizer: card detect, write protect, ready, and two battery-level sense lines. Any change on a status line whose mask bit is clear raises the card-change flag. Three single-cycle event pulses from neighbouring logic raise the error, programming-timer and interlock flags. The I/O-check and stop-CPU flags are reached only through software writes.

Software uses an 8-bit register port with four addresses:

| Address | Register | Access |
|---|---|---|
| 0 | event flags | read/write |
| 1 | interrupt enable and drive code | read/write |
| 2 | live synchronized status | read-only |
| 3 | change masks | read/write |

A write to the flag register carries a two-bit command in its low bits. The command sets flags, clears flags or loads them directly. Read data is registered and appears one cycle after the address is presented. The interrupt pin is modelled as a level plus an output enable, so a pad cell can realise any of the four drive codes.

Top module: `card_irq_ctrl`

## Requirements
- R1: With `rst` high at a clock edge, the flag, enable and mask registers become zero. After reset every readable register reads 0x00 and `irq_oe` is low.
- R2: Flag positions in the flag register are:

  | Bit | Flag |
  |---|---|
  | 7 | I/O check |
  | 6 | card change |
  | 5 | error |
  | 4 | programming timer |
  | 3 | interlock change |
  | 2 | stop-CPU |

  A one-cycle pulse on `err_evt`, `prog_evt` or `ilock_evt` sets bit 5, bit 4 or bit 3 at the next clock edge.
- R3: A write to address 0 whose bits 1:0 are 2'b10 sets every flag whose data bit is 1. Bits 1:0 of the flag register always read 0.
- R4: A write to address 0 whose bits 1:0 are 2'b01 clears every flag whose data bit is 1.
- R5: A write to address 0 whose bits 1:0 are 2'b11 loads data bits 7:2 into the flags.
- R6: A write to address 0 whose bits 1:0 are 2'b00 leaves the flags unchanged. Without writes or events the flags hold.
- R7: A hardware event and a software clear or load of the same flag in the same cycle leave the flag set.
- R8: The enable register is at address 1.
  - Bits 6, 5, 4 and 3 enable the flags of the same position onto the interrupt.
  - Bits 7 and 2 always read 0.
  - The I/O-check and stop-CPU flags never raise the interrupt.
- R9: Enable bits 1:0 select the drive one cycle after the register changes:
  - 0: high impedance (`irq_oe`=0).
  - 1: active-low open drain (`irq_out`=0, `irq_oe`=active).
  - 2: active-low totem pole (`irq_oe`=1, `irq_out`=!active).
  - 3: active-high totem pole (`irq_oe`=1, `irq_out`=active).
- R10: Address 2 returns the synchronized status in bits 7:3, in the order card detect, write protect, ready, low-battery 2, low-battery 1. These bits come from `sts_in[4:0]` in that order. Bits 2:0 read 0, and writes to address 2 are ignored.
- R11: Each input passes two flops. A difference between the current and previous synchronized sample of an unmasked source sets the card-change flag. For ready, this applies on both the rising and the falling edge.
- R12: Mask register bits 7:3 at address 3 follow the same order as R10. A 1 stops change detection for that source only. Bits 2:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| sts_in | input | 5 | Raw status: [4] card detect, [3] write protect, [2] ready, [1] low-battery 2, [0] low-battery 1 |
| err_evt | input | 1 | Error event pulse |
| prog_evt | input | 1 | Programming-timer event pulse |
| ilock_evt | input | 1 | Interlock-change event pulse |
| irq_out | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The bench builds the block with its defaults: five status sources and a two-stage synchronizer. This places the card-change flag three edges after a status input moves, which the bench waits out before reading. These widths match the fixed bit positions of the status and mask registers, so every source and every mask bit is reachable from the ports. All four drive codes can be exercised, and an event can be made to collide with a clear or a load in the same cycle.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;

  localparam int REG_W = 8;

  // flag positions in the status byte
  localparam int FLG_IOCHK = 7;
  localparam int FLG_CARD  = 6;
  localparam int FLG_ERR   = 5;
  localparam int FLG_PROG  = 4;
  localparam int FLG_ILOCK = 3;
  localparam int FLG_STOP  = 2;

  // bits 1:0 are command bits and are never stored
  localparam logic [REG_W-1:0] FLAG_STORE = 8'hFC;
  // enable bits that may raise the interrupt
  localparam logic [REG_W-1:0] ENA_IRQ_BITS = 8'h78;
  // writable bits of the enable register
  localparam logic [REG_W-1:0] ENA_WRITABLE = 8'h7B;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_CLR  = 2'b01,
    CMD_SET  = 2'b10,
    CMD_LOAD = 2'b11
  } wcmd_e;

  typedef enum logic [1:0] {
    DRV_HIZ     = 2'd0,
    DRV_OD_LOW  = 2'd1,
    DRV_PP_LOW  = 2'd2,
    DRV_PP_HIGH = 2'd3
  } drv_e;

  typedef enum logic [1:0] {
    RA_FLAGS  = 2'd0,
    RA_ENABLE = 2'd1,
    RA_LIVE   = 2'd2,
    RA_MASK   = 2'd3
  } raddr_e;

endpackage

// File: rtl/card_irq_sync.sv
// Synchronizes the status lines and reports an unmasked change.
module card_irq_sync #(
  parameter int N_SRC  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] raw,
  input  logic [N_SRC-1:0] mask,
  output logic [N_SRC-1:0] level,
  output logic             change
);
  localparam int CHAIN_W = N_SRC * STAGES;

  logic [CHAIN_W-1:0] chain;
  logic [N_SRC-1:0]   prev;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN_W-N_SRC-1:0], raw};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= raw;
      end
    end
  endgenerate

  assign level = chain[CHAIN_W-1 -: N_SRC];

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= level;
  end

  assign change = |((level ^ prev) & ~mask);
endmodule

// File: rtl/card_irq_flags.sv
// Event flag register with set/clear/load writes; events take priority.
module card_irq_flags
  import card_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] hw_evt,
  output logic [REG_W-1:0] flags
);
  wcmd_e            cmd;
  logic [REG_W-1:0] sw_next;
  logic [REG_W-1:0] next;

  assign cmd = wcmd_e'(wdata[1:0]);

  always_comb begin
    sw_next = flags;
    if (wr) begin
      unique case (cmd)
        CMD_SET:  sw_next = flags | wdata;
        CMD_CLR:  sw_next = flags & ~wdata;
        CMD_LOAD: sw_next = wdata;
        default:  sw_next = flags;
      endcase
    end
    next = (sw_next | hw_evt) & FLAG_STORE;
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= next;
  end
endmodule

// File: rtl/card_irq_drive.sv
// Registered interrupt pin level and output enable.
module card_irq_drive
  import card_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] flags,
  input  logic [REG_W-1:0] ena,
  output logic             irq_out,
  output logic             irq_oe
);
  logic active;
  drv_e code;
  logic lvl_d, oe_d;

  assign active = |(flags & ena & ENA_IRQ_BITS);
  assign code   = drv_e'(ena[1:0]);

  always_comb begin
    unique case (code)
      DRV_OD_LOW:  begin lvl_d = 1'b0;    oe_d = active; end
      DRV_PP_LOW:  begin lvl_d = ~active; oe_d = 1'b1;   end
      DRV_PP_HIGH: begin lvl_d = active;  oe_d = 1'b1;   end
      default:     begin lvl_d = 1'b0;    oe_d = 1'b0;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= 1'b0;
      irq_oe  <= 1'b0;
    end else begin
      irq_out <= lvl_d;
      irq_oe  <= oe_d;
    end
  end
endmodule

// File: rtl/card_irq_ctrl.sv
module card_irq_ctrl
  import card_irq_pkg::*;
#(
  parameter int N_SRC       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [N_SRC-1:0] sts_in,
  input  logic             err_evt,
  input  logic             prog_evt,
  input  logic             ilock_evt,
  output logic             irq_out,
  output logic             irq_oe
);
  localparam int PAD_W = REG_W - N_SRC;

  logic [REG_W-1:0] flags_q;
  logic [REG_W-1:0] ena_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] live;
  logic             card_chg;
  logic [REG_W-1:0] hw_evt;
  raddr_e           ra;

  assign ra = raddr_e'(reg_addr);

  card_irq_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .raw(sts_in), .mask(mask_q),
    .level(live), .change(card_chg)
  );

  always_comb begin
    hw_evt            = '0;
    hw_evt[FLG_CARD]  = card_chg;
    hw_evt[FLG_ERR]   = err_evt;
    hw_evt[FLG_PROG]  = prog_evt;
    hw_evt[FLG_ILOCK] = ilock_evt;
  end

  card_irq_flags i_flags (
    .clk(clk), .rst(rst), .wr(reg_wr && ra == RA_FLAGS),
    .wdata(reg_wdata), .hw_evt(hw_evt), .flags(flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q  <= '0;
      mask_q <= '0;
    end else if (reg_wr) begin
      if (ra == RA_ENABLE) ena_q  <= reg_wdata & ENA_WRITABLE;
      if (ra == RA_MASK)   mask_q <= reg_wdata[REG_W-1 -: N_SRC];
    end
  end

  card_irq_drive i_drive (
    .clk(clk), .rst(rst), .flags(flags_q), .ena(ena_q),
    .irq_out(irq_out), .irq_oe(irq_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (ra)
        RA_FLAGS:  reg_rdata <= flags_q;
        RA_ENABLE: reg_rdata <= ena_q;
        RA_LIVE:   reg_rdata <= {live, {PAD_W{1'b0}}};
        default:   reg_rdata <= {mask_q, {PAD_W{1'b0}}};
      endcase
    end
  end
endmodule

// File: rtl/card_irq_ctrl_chk.sv
module card_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       err_evt,
  input logic       prog_evt,
  input logic       ilock_evt,
  input logic       card_chg,
  input logic [7:0] flags_q,
  input logic [7:0] ena_q,
  input logic       irq_out,
  input logic       irq_oe
);
  logic flag_wr;
  logic any_evt;
  assign flag_wr = reg_wr && reg_addr == 2'd0 && reg_wdata[1:0] != 2'b00;
  assign any_evt = err_evt || prog_evt || ilock_evt || card_chg;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_oe && flags_q == 8'h00 && ena_q == 8'h00));

  assert_err_sets_R2: assert property (@(posedge clk) disable iff (rst)
    err_evt |=> flags_q[5]);

  assert_clear_card_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[1:0] == 2'b01 && reg_wdata[6] && !card_chg)
    |=> !flags_q[6]);

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!flag_wr && !any_evt) |=> $stable(flags_q));

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (ilock_evt && reg_wr && reg_addr == 2'd0 && reg_wdata[3] && reg_wdata[0]) |=> flags_q[3]);

  assert_no_unenabled_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (ena_q[1:0] == 2'd3 && (flags_q & ena_q & 8'h78) == 8'h00) |=> !irq_out);

  assert_hiz_R9: assert property (@(posedge clk) disable iff (rst)
    (ena_q[1:0] == 2'd0) |=> !irq_oe);

  assert_open_drain_R9: assert property (@(posedge clk) disable iff (rst)
    (ena_q[1:0] == 2'd1) |=> !irq_out);

  assert_totem_R9: assert property (@(posedge clk) disable iff (rst)
    (ena_q[1] == 1'b1) |=> irq_oe);
endmodule

bind card_irq_ctrl card_irq_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .err_evt(err_evt), .prog_evt(prog_evt),
  .ilock_evt(ilock_evt), .card_chg(card_chg), .flags_q(flags_q),
  .ena_q(ena_q), .irq_out(irq_out), .irq_oe(irq_oe)
);

// File: tb/test_card_irq_ctrl.sv
`timescale 1ns/1ps
module test_card_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [4:0] sts_in = 5'b0;
  logic       err_evt = 1'b0, prog_evt = 1'b0, ilock_evt = 1'b0;
  logic       irq_out, irq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  card_irq_ctrl i_card_irq_ctrl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sts_in(sts_in),
    .err_evt(err_evt), .prog_evt(prog_evt), .ilock_evt(ilock_evt),
    .irq_out(irq_out), .irq_oe(irq_oe)
  );

  // {write data, expected flag readback}; command in data bits 1:0
  localparam logic [15:0] TBL [8] = '{
    {8'hFE, 8'hFC},  // set all
    {8'h41, 8'hBC},  // clear card change
    {8'hFC, 8'hBC},  // no command
    {8'h2B, 8'h28},  // load
    {8'hFD, 8'h00},  // clear all
    {8'h86, 8'h84},  // set io-check, stop
    {8'h03, 8'h00},  // load zero
    {8'h0E, 8'h0C}   // set interlock, stop
  };

  function automatic string cmd_req(input logic [1:0] c);
    case (c)
      2'b10:   return "R3";
      2'b01:   return "R4";
      2'b11:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    idle(4);
    rst = 1'b0;
    // R1 reset state
    rd(2'd0, v); chk("R1", v, 8'h00);
    rd(2'd1, v); chk("R1", v, 8'h00);
    rd(2'd3, v); chk("R1", v, 8'h00);
    chk("R1", {7'd0, irq_oe}, 8'h00);

    // command table walk: R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, TBL[i][15:8]);
      rd(2'd0, v);
      chk(cmd_req(TBL[i][9:8]), v, TBL[i][7:0]);
    end
    wr(2'd0, 8'h03);

    // R2 event pulses
    @(negedge clk); err_evt = 1'b1; @(negedge clk); err_evt = 1'b0;
    rd(2'd0, v); chk("R2", v, 8'h20);
    @(negedge clk); prog_evt = 1'b1; @(negedge clk); prog_evt = 1'b0;
    rd(2'd0, v); chk("R2", v, 8'h30);
    @(negedge clk); ilock_evt = 1'b1; @(negedge clk); ilock_evt = 1'b0;
    rd(2'd0, v); chk("R2", v, 8'h38);

    // R7 event against clear, then against load
    @(negedge clk);
    ilock_evt = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h09; reg_wr = 1'b1;
    @(negedge clk);
    ilock_evt = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v); chk("R7", v, 8'h38);
    wr(2'd0, 8'h19);
    rd(2'd0, v); chk("R4", v, 8'h20);
    @(negedge clk);
    prog_evt = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h03; reg_wr = 1'b1;
    @(negedge clk);
    prog_evt = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v); chk("R7", v, 8'h10);
    wr(2'd0, 8'h22);   // flags 0x30

    // R9 drive codes with error flag active
    wr(2'd1, 8'h23); idle(1); chk("R9", {6'd0, irq_oe, irq_out}, 8'h03);
    wr(2'd1, 8'h22); idle(1); chk("R9", {6'd0, irq_oe, irq_out}, 8'h02);
    wr(2'd1, 8'h21); idle(1); chk("R9", {6'd0, irq_oe, irq_out}, 8'h02);
    wr(2'd1, 8'h20); idle(1); chk("R9", {6'd0, irq_oe, irq_out}, 8'h00);
    // R8 source not enabled
    wr(2'd1, 8'h0B); idle(1); chk("R8", {6'd0, irq_oe, irq_out}, 8'h02);
    wr(2'd1, 8'h09); idle(1); chk("R9", {6'd0, irq_oe, irq_out}, 8'h00);
    wr(2'd1, 8'h0A); idle(1); chk("R9", {6'd0, irq_oe, irq_out}, 8'h03);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R8", v, 8'h7B);
    chk("R8", {6'd0, irq_oe, irq_out}, 8'h03);
    wr(2'd0, 8'h87);   // only io-check and stop flags
    idle(1); chk("R8", {6'd0, irq_oe, irq_out}, 8'h02);
    wr(2'd0, 8'h03);

    // R10 R11 status sync and change
    @(negedge clk); sts_in = 5'b10110;
    idle(6);
    rd(2'd2, v); chk("R10", v, 8'hB0);
    rd(2'd0, v); chk("R11", v, 8'h40);
    chk("R11", {6'd0, irq_oe, irq_out}, 8'h03);
    wr(2'd0, 8'h41);
    @(negedge clk); sts_in[2] = 1'b0;   // ready falls
    idle(6);
    rd(2'd0, v); chk("R11", v, 8'h40);
    wr(2'd0, 8'h41);

    // R12 masks
    wr(2'd3, 8'h27);
    rd(2'd3, v); chk("R12", v, 8'h20);
    @(negedge clk); sts_in[2] = 1'b1;   // ready rises, masked
    idle(6);
    rd(2'd0, v); chk("R12", v, 8'h00);
    rd(2'd2, v); chk("R10", v, 8'hB0);
    @(negedge clk); sts_in[0] = 1'b1;   // low-battery 1, unmasked
    idle(6);
    rd(2'd0, v); chk("R12", v, 8'h40);

    // R10 write to live status ignored
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R10", v, 8'hB8);
    rd(2'd3, v); chk("R10", v, 8'h20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule